// File: doc/BRIEF.md
# Multi-CPU Level-Sensitive Interrupt Router

This block collects a vector of level-sensitive interrupt lines and delivers them to a small cluster of CPUs, four by default. Every source has a global enable bit and a routing bitmap that names the CPUs it may reach. Every CPU has its own private mask over all sources. A CPU's interrupt output is high while at least one source is active, enabled, routed to that CPU and unmasked by it. One source, the per-CPU private timer, skips the global enable and is gated only by routing and by each CPU's own mask.

Software reaches the block through one register port. A bank-select bit picks the shared bank or the per-CPU bank, and a CPU index tells the block which CPU is making the access. Enable and mask bits are not written as bitmaps. A source number is written to a "set" or a "clear" address, so no read-modify-write sequence is needed. Reading the acknowledge address returns the lowest-numbered source that qualifies for the reading CPU. The read has no side effect: a source stays pending as long as its line stays high. Nothing stops several CPUs from acknowledging the same source.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every enable is clear, every mask bit is set and every routing field is zero. All cpu_irq outputs are low and an acknowledge read returns 0x3FF.
- R2: A shared-bank write of source number n to offset 0x030 sets the global enable of source n. A write of n to offset 0x034 clears it.
- R3: A per-CPU-bank write of n to offset 0x048 masks source n for the CPU named by bus_cpu, and a write of n to offset 0x04C unmasks it. No other CPU's mask changes.
- R4: The routing word of source n is at shared offset 0x100 + 4*n. Bits [NCPU-1:0] hold the target-CPU bitmap, with bit c meaning CPU c. The word reads back with all higher bits zero.
- R5: A per-CPU-bank read at offset 0x044 returns, in bits [9:0], the lowest-numbered source that qualifies for that CPU, with bits [31:10] zero. It returns 0x3FF when no source qualifies. Each read answer appears on bus_rdata with bus_rvalid high on the cycle after the read request.
- R6: A shared-bank read at offset 0x000 returns the number of implemented sources in bits [11:2].
- R7: Source 5 (the private timer) ignores the global enable. It reaches a CPU when it is active, routed to that CPU and unmasked by that CPU.
- R8: Sources are level-sensitive. An acknowledge read does not clear anything, so repeated reads, and reads by several CPUs, return the same source while its line stays high. Dropping the line removes the request.
- R9: Set and clear writes that carry a source number of NSRC or more change no state.
- R10: cpu_irq is registered. A change on src_lvl, or a register write, shows on cpu_irq one clock after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NSRC | Level-sensitive interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_bank | input | 1 | 0 selects the shared bank, 1 selects the per-CPU bank |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_addr | input | 12 | Byte offset within the selected bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds a read answer |
| cpu_irq | output | NCPU | Registered interrupt request, one per CPU |

## Verification
The hardest condition to reach from the ports is a case where the per-source enable, the routing bitmap and the per-CPU mask disagree with each other for the same source on different CPUs. An example is the timer source: it is routed to two CPUs, unmasked on one and never enabled, yet it must still fire. The stimulus builds these states one register write at a time. After each write it reads the acknowledge register from both the CPU that should see the source and the CPU that should not. A table of line patterns then runs the priority choice across the full source range. Out-of-range source numbers are written whose low bits alias a live source, so an encoder that truncates the value would be exposed.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ADDR_W = 12;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] ID_NONE = '1;

  // shared bank
  localparam logic [ADDR_W-1:0] OFS_CTRL       = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_SET     = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR     = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ROUTE_BASE = 12'h100;
  // per-CPU bank
  localparam logic [ADDR_W-1:0] OFS_ACK        = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_MASK_SET   = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR   = 12'h04C;

  typedef enum logic {BANK_SHARED = 1'b0, BANK_CPU = 1'b1} bank_e;
endpackage

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
  import irq_route_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int NCPU      = 4,
  parameter int TIMER_SRC = 5,
  localparam int SRC_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic                        route_hit,
  output logic [NCPU-1:0]             route_rd,
  output logic [NSRC-1:0]             gate,
  output logic [NSRC-1:0][NCPU-1:0]   route
);
  logic [NSRC-1:0]           en_q;
  logic [NSRC-1:0][NCPU-1:0] route_q;
  logic                      num_ok;
  logic [SRC_W-1:0]          num;
  logic [ADDR_W-1:0]         roff;
  logic [SRC_W-1:0]          ridx;

  assign num_ok = (wdata < 32'(NSRC));
  assign num    = wdata[SRC_W-1:0];

  assign roff      = addr - OFS_ROUTE_BASE;
  assign ridx      = roff[SRC_W+1:2];
  assign route_hit = (addr >= OFS_ROUTE_BASE) && (roff[1:0] == 2'b00) &&
                     (roff[ADDR_W-1:2] < (ADDR_W-2)'(NSRC));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_en && num_ok) begin
      if (addr == OFS_EN_SET) en_q[num] <= 1'b1;
      if (addr == OFS_EN_CLR) en_q[num] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
    end else if (wr_en && route_hit) begin
      route_q[ridx] <= wdata[NCPU-1:0];
    end
  end

  assign route_rd = route_hit ? route_q[ridx] : '0;
  assign route    = route_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_gate
    if (s == TIMER_SRC) begin : g_timer
      assign gate[s] = 1'b1;
    end else begin : g_plain
      assign gate[s] = en_q[s];
    end
  end
endmodule

// File: rtl/irq_cpu_mask.sv
module irq_cpu_mask
  import irq_route_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCPU   = 4,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [CPU_W-1:0]            cpu,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [NCPU-1:0][NSRC-1:0]   mask
);
  logic             num_ok;
  logic [SRC_W-1:0] num;

  assign num_ok = (wdata < 32'(NSRC)) && (32'(cpu) < 32'(NCPU));
  assign num    = wdata[SRC_W-1:0];

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) begin
        mask[c] <= '1;
      end else if (wr_en && num_ok && (cpu == CPU_W'(c))) begin
        if (addr == OFS_MASK_SET) mask[c][num] <= 1'b1;
        if (addr == OFS_MASK_CLR) mask[c][num] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NCPU = 4
) (
  input  logic [NSRC-1:0]             src_lvl,
  input  logic [NSRC-1:0]             gate,
  input  logic [NSRC-1:0][NCPU-1:0]   route,
  input  logic [NCPU-1:0][NSRC-1:0]   mask,
  output logic [NCPU-1:0]             hit,
  output logic [NCPU-1:0][ID_W-1:0]   best
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NSRC-1:0] qual;

    always_comb begin
      for (int s = 0; s < NSRC; s++) begin
        qual[s] = src_lvl[s] & gate[s] & route[s][c] & ~mask[c][s];
      end
    end

    assign hit[c] = |qual;

    // lowest number wins: scan downward so the last hit kept is the smallest
    always_comb begin
      best[c] = ID_NONE;
      for (int s = NSRC - 1; s >= 0; s--) begin
        if (qual[s]) best[c] = ID_W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int NCPU      = 4,
  parameter int TIMER_SRC = 5,
  localparam int CPU_W    = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_lvl,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_bank,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic [NCPU-1:0]    cpu_irq
);
  logic                      shared_wr, cpu_wr;
  logic                      route_hit;
  logic [NCPU-1:0]           route_rd;
  logic [NSRC-1:0]           gate;
  logic [NSRC-1:0][NCPU-1:0] route;
  logic [NCPU-1:0][NSRC-1:0] mask;
  logic [NCPU-1:0]           hit;
  logic [NCPU-1:0][ID_W-1:0] best;
  logic [31:0]               rd_mux;

  assign shared_wr = bus_wr && (bus_bank == BANK_SHARED);
  assign cpu_wr    = bus_wr && (bus_bank == BANK_CPU);

  irq_src_cfg #(.NSRC(NSRC), .NCPU(NCPU), .TIMER_SRC(TIMER_SRC)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(shared_wr), .addr(bus_addr), .wdata(bus_wdata),
    .route_hit(route_hit), .route_rd(route_rd), .gate(gate), .route(route)
  );

  irq_cpu_mask #(.NSRC(NSRC), .NCPU(NCPU)) u_mask (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .cpu(bus_cpu), .addr(bus_addr),
    .wdata(bus_wdata), .mask(mask)
  );

  irq_qualify #(.NSRC(NSRC), .NCPU(NCPU)) u_qual (
    .src_lvl(src_lvl), .gate(gate), .route(route), .mask(mask),
    .hit(hit), .best(best)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_bank == BANK_SHARED) begin
      if (bus_addr == OFS_CTRL) rd_mux = 32'(NSRC) << 2;
      else if (route_hit)       rd_mux = 32'(route_rd);
    end else begin
      if (bus_addr == OFS_ACK) begin
        if (32'(bus_cpu) < 32'(NCPU)) rd_mux = 32'(best[bus_cpu]);
        else                          rd_mux = 32'(ID_NONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      cpu_irq    <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
      cpu_irq <= hit;
    end
  end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NCPU = 4,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NSRC-1:0]    src_lvl,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic               bus_bank,
  input logic [CPU_W-1:0]   bus_cpu,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic [NCPU-1:0]    cpu_irq
);
  logic ack_rd, ctrl_rd;
  assign ack_rd  = bus_rd && bus_bank && (bus_addr == OFS_ACK);
  assign ctrl_rd = bus_rd && !bus_bank && (bus_addr == OFS_CTRL);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (cpu_irq == '0));

  p_idle_lines_r8: assert property (@(posedge clk) disable iff (rst)
    (src_lvl == '0) |=> (cpu_irq == '0));

  p_ack_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && (src_lvl == '0)) |=> (bus_rdata == 32'h3FF));

  p_ack_range_r5: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> ((bus_rdata[31:10] == '0) &&
                ((bus_rdata[9:0] == 10'h3FF) || (32'(bus_rdata[9:0]) < 32'(NSRC)))));

  p_ctrl_count_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> (32'(bus_rdata[11:2]) == 32'(NSRC)));

  p_rvalid_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NSRC(NSRC), .NCPU(NCPU)) u_chk (
  .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_bank(bus_bank), .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
);

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam int NCPU = 4;
  localparam int NVEC = 6;
  // {line pattern, expected acknowledge value for CPU 0}
  localparam logic [41:0] VEC [NVEC] = '{
    {32'h0000_0000, 10'h3FF},
    {32'h8000_0000, 10'd31},
    {32'h0000_0030, 10'd4},
    {32'h0000_0001, 10'd0},
    {32'hFFFF_0000, 10'd16},
    {32'h0000_0020, 10'd5}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NSRC-1:0]  src_lvl = '0;
  logic             bus_wr = 1'b0, bus_rd = 1'b0, bus_bank = 1'b0;
  logic [1:0]       bus_cpu = '0;
  logic [11:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_rvalid;
  logic [NCPU-1:0]  cpu_irq;
  int checks = 0, failures = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_ctrl #(.NSRC(NSRC), .NCPU(NCPU)) u0 (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_bank(bus_bank), .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bank, input logic [1:0] cpu, input logic [11:0] a,
                    input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_bank = bank; bus_cpu = cpu; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic bank, input logic [1:0] cpu, input logic [11:0] a,
                    output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_bank = bank; bus_cpu = cpu; bus_addr = a;
    @(negedge clk);
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(cpu_irq), 32'h0);
    rd(1'b1, 2'd0, 12'h044, rv); chk("R1 ack", rv, 32'h3FF);
    rd(1'b0, 2'd0, 12'h10C, rv); chk("R1 R4 route", rv, 32'h0);
    // R6 source count
    rd(1'b0, 2'd0, 12'h000, rv); chk("R6 ctrl", 32'(rv[11:2]), 32'd32);

    // R7 timer source without global enable
    src_lvl[5] = 1'b1;
    wr(1'b0, 2'd0, 12'h114, 32'h3);
    wr(1'b1, 2'd0, 12'h04C, 32'd5);
    settle();
    chk("R7 irq", 32'(cpu_irq), 32'h1);
    rd(1'b1, 2'd0, 12'h044, rv); chk("R7 ack cpu0", rv, 32'd5);
    rd(1'b1, 2'd1, 12'h044, rv); chk("R3 ack masked cpu1", rv, 32'h3FF);
    src_lvl[5] = 1'b0;
    wr(1'b1, 2'd0, 12'h048, 32'd5);

    // R2 global enable
    src_lvl[7] = 1'b1;
    wr(1'b0, 2'd0, 12'h11C, 32'h4);
    wr(1'b1, 2'd2, 12'h04C, 32'd7);
    settle();
    chk("R2 not enabled", 32'(cpu_irq), 32'h0);
    wr(1'b0, 2'd0, 12'h030, 32'd7);
    settle();
    chk("R2 enabled", 32'(cpu_irq), 32'h4);
    rd(1'b1, 2'd2, 12'h044, rv); chk("R2 ack cpu2", rv, 32'd7);
    wr(1'b0, 2'd0, 12'h034, 32'd7);
    settle();
    chk("R2 cleared", 32'(cpu_irq), 32'h0);
    // R9 out-of-range number aliasing source 7
    wr(1'b0, 2'd0, 12'h030, 32'd39);
    settle();
    chk("R9 enable ignored", 32'(cpu_irq), 32'h0);
    wr(1'b1, 2'd2, 12'h048, 32'd39);
    wr(1'b0, 2'd0, 12'h030, 32'd7);
    settle();
    chk("R9 mask ignored", 32'(cpu_irq), 32'h4);
    wr(1'b0, 2'd0, 12'h034, 32'd7);
    src_lvl[7] = 1'b0;

    // R8 level-sensitive, shared by two CPUs; R10 latency
    wr(1'b0, 2'd0, 12'h124, 32'h9);
    wr(1'b0, 2'd0, 12'h030, 32'd9);
    wr(1'b1, 2'd0, 12'h04C, 32'd9);
    wr(1'b1, 2'd3, 12'h04C, 32'd9);
    settle();
    chk("R10 before edge", 32'(cpu_irq), 32'h0);
    src_lvl[9] = 1'b1;
    @(negedge clk);
    chk("R10 one cycle", 32'(cpu_irq), 32'h9);
    rd(1'b1, 2'd0, 12'h044, rv); chk("R8 ack cpu0", rv, 32'd9);
    rd(1'b1, 2'd3, 12'h044, rv); chk("R8 ack cpu3", rv, 32'd9);
    rd(1'b1, 2'd0, 12'h044, rv); chk("R8 ack again", rv, 32'd9);
    chk("R8 still high", 32'(cpu_irq), 32'h9);
    src_lvl[9] = 1'b0;
    @(negedge clk);
    chk("R8 line dropped", 32'(cpu_irq), 32'h0);

    // R4 routing readback keeps only the CPU bitmap
    wr(1'b0, 2'd0, 12'h10C, 32'hFFFF_FFF3);
    rd(1'b0, 2'd0, 12'h10C, rv); chk("R4 route", rv, 32'h3);
    wr(1'b0, 2'd0, 12'h10C, 32'h0);

    // R5 table: all sources enabled, routed to CPU 0 only, unmasked on CPU 0
    for (int s = 0; s < NSRC; s++) begin
      wr(1'b0, 2'd0, 12'h030, 32'(s));
      wr(1'b0, 2'd0, 12'(12'h100 + 4 * s), 32'h1);
      wr(1'b1, 2'd0, 12'h04C, 32'(s));
    end
    for (int i = 0; i < NVEC; i++) begin
      src_lvl = VEC[i][41:10];
      settle();
      rd(1'b1, 2'd0, 12'h044, rv);
      chk("R5 table ack", rv, 32'(VEC[i][9:0]));
      chk("R5 table irq", 32'(cpu_irq), (VEC[i][9:0] == 10'h3FF) ? 32'h0 : 32'h1);
    end

    // R3 masking moves the choice to the next source
    src_lvl = 32'h30;
    wr(1'b1, 2'd0, 12'h048, 32'd4);
    settle();
    rd(1'b1, 2'd0, 12'h044, rv); chk("R3 next source", rv, 32'd5);
    wr(1'b1, 2'd0, 12'h048, 32'd5);
    settle();
    rd(1'b1, 2'd0, 12'h044, rv); chk("R3 all masked", rv, 32'h3FF);
    chk("R3 irq low", 32'(cpu_irq), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule